// File: doc/BRIEF.md
# Programmable CIC Decimation Filter

This block lowers the sample rate of a signed data stream by a power of two that is chosen at run time, using only adders, subtractors and registers. Samples enter at the fast rate, qualified by an input valid. They pass through a cascade of `STAGES` recursive integrators that hold their running sums in carry-save form. A ratio counter then keeps one integrator result out of every R accepted samples and raises the low-rate strobe. A cascade of `STAGES` differencing (comb) stages running at the reduced rate follows, and a final arithmetic right shift restores unity gain for the ratio in use.

Each integrator and comb pair acts as a boxcar FIR with linear phase. More stages give stronger rejection of the aliasing bands. The internal word is `IN_W + STAGES*MAX_LOG` bits wide, so the integrators may wrap in two's complement without harm, because the combs cancel the wrap exactly. The integrators form a pipelined cascade: stage i adds the registered value of stage i-1. This adds a delay of `STAGES-1` input samples in front of the usual response.

A new ratio is accepted only while reset is held or on the sample that closes a period. Every output period is therefore complete and is scaled by the ratio it was gathered with.

Top module: `cic_decim`

## Requirements
- R1: While `rst` is high at a clock edge, every integrator, comb and counter register is cleared and the ratio register loads from `rate_sel`. After reset, `out_valid` is 0 and `out_data` is 0 until the first output period completes.
- R2: Suppose the sample that completes a period is accepted at clock edge t. Then `out_valid` is high for exactly the one cycle between edges t+1 and t+2, and never for two consecutive cycles.
- R3: A `rate_sel` code j selects the ratio R = 2^(j+1), limited to 2^MAX_LOG. A period is exactly R accepted samples, and one output is produced per period.
- R4: A change of `rate_sel` takes effect only at reset or on the sample that closes a period. The period in progress completes at the old ratio, and its output is scaled by the old ratio.
- R5: A constant input x, held long enough to pass the start-up transient, yields `out_data` = x at every ratio (unity DC gain).
- R6: All arithmetic is modulo 2^W, with W = IN_W + STAGES*MAX_LOG. On each accepted sample, integrator k (k > 0) adds the previous value of integrator k-1, and integrator 0 adds the sign-extended sample. At a period end, the updated last integrator value feeds STAGES cascaded first differences, each against that stage's value at the previous period end. The W-bit result is read as signed, shifted right arithmetically by STAGES*log2(R), and its low IN_W bits form `out_data`.
- R7: A cycle with `in_valid` low changes no integrator, counter or ratio state. The output sequence depends only on the accepted samples.
- R8: Full-scale DC input of either polarity (-2^(IN_W-1) and 2^(IN_W-1)-1) at the largest ratio reproduces the input exactly, even though the integrators wrap many times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | High-rate enable: the sample on `in_data` is accepted this cycle |
| in_data | input | IN_W | Signed input sample |
| rate_sel | input | SEL_W | Ratio code j, R = 2^(j+1) |
| out_valid | output | 1 | Low-rate strobe, one cycle per output sample |
| out_data | output | IN_W | Signed decimated output sample |

## Verification
The bench builds the block with IN_W = 12, STAGES = 3 and MAX_LOG = 4, giving a 24-bit internal word and a 2-bit code that covers all four ratios, 2, 4, 8 and 16. At R = 16 a full-scale negative input fills the internal word to exactly -2^23, so the widest comb result and the largest shift are both exercised, while the integrators wrap many times. A cycle-exact behavioural model of the stated arithmetic runs beside the block. It predicts every strobe position and value through ratio changes in mid-period and through irregular gaps in the input valid.

// File: rtl/cic_pkg.sv
package cic_pkg;

    // Maps a ratio code j to log2 of the decimation ratio (j+1), limited to max_log.
    function automatic int unsigned ratio_log(input int unsigned code, input int unsigned max_log);
        int unsigned lg;
        lg = code + 1;
        if (lg > max_log) lg = max_log;
        return lg;
    endfunction

    // Width of a field able to hold the value n.
    function automatic int unsigned bits_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/cic_rate_ctrl.sv
module cic_rate_ctrl #(
    parameter int MAX_LOG = 4,
    parameter int SEL_W   = 2,
    parameter int LOG_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             strobe,
    output logic [LOG_W-1:0] cur_log
);

    typedef struct packed {
        logic [MAX_LOG-1:0] cnt;
        logic [LOG_W-1:0]   lg;
    } ctrl_t;

    ctrl_t               st_d, st_q;
    logic [MAX_LOG-1:0]  mask;
    logic [LOG_W-1:0]    new_lg;

    always_comb begin
        new_lg = LOG_W'(cic_pkg::ratio_log(32'(rate_sel), MAX_LOG));
        mask   = {MAX_LOG{1'b1}} >> (LOG_W'(MAX_LOG) - st_q.lg);
        strobe = in_valid && !rst && (st_q.cnt == mask);
        st_d   = st_q;
        if (in_valid) begin
            if (strobe) begin
                st_d.cnt = '0;
                st_d.lg  = new_lg;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (rst) begin
            st_d.cnt = '0;
            st_d.lg  = new_lg;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cur_log = st_q.lg;

    // R4: the ratio only moves on a period-closing sample
    a_r4_ratio_hold: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(cur_log));

    // R3: the counter never runs past R-1
    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= mask);

    // R3: a period end restarts the count
    a_r3_restart: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (st_q.cnt == '0));

    // R7: idle cycles leave the counter alone
    a_r7_count_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(st_q.cnt));

endmodule

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
    parameter int IN_W   = 12,
    parameter int REG_W  = 24,
    parameter int STAGES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic [REG_W-1:0] acc_out
);

    typedef logic [STAGES-1:0][REG_W-1:0] vec_t;

    typedef struct packed {
        vec_t s;   // partial sum vectors
        vec_t c;   // carry vectors
    } integ_t;

    integ_t                  st_d, st_q;
    logic [REG_W-1:0]        x_ext;
    logic [REG_W-1:0]        feed_s [STAGES];
    logic [REG_W-1:0]        feed_c [STAGES];

    // 3:2 compressor; element 0 is the sum word, element 1 the shifted carry word.
    function automatic logic [1:0][REG_W-1:0] csa(input logic [REG_W-1:0] a,
                                                  input logic [REG_W-1:0] b,
                                                  input logic [REG_W-1:0] e);
        logic [1:0][REG_W-1:0] r;
        r[0] = a ^ b ^ e;
        r[1] = ((a & b) | (a & e) | (b & e)) << 1;
        return r;
    endfunction

    always_comb begin
        logic [1:0][REG_W-1:0] t1;
        logic [1:0][REG_W-1:0] t2;
        x_ext     = {{(REG_W-IN_W){in_data[IN_W-1]}}, in_data};
        feed_s[0] = x_ext;
        feed_c[0] = '0;
        for (int i = 1; i < STAGES; i++) begin
            feed_s[i] = st_q.s[i-1];
            feed_c[i] = st_q.c[i-1];
        end
        st_d = st_q;
        t1   = '0;
        t2   = '0;
        if (in_valid) begin
            for (int i = 0; i < STAGES; i++) begin
                t1 = csa(st_q.s[i], st_q.c[i], feed_s[i]);
                t2 = csa(t1[0], t1[1], feed_c[i]);
                st_d.s[i] = t2[0];
                st_d.c[i] = t2[1];
            end
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // The only carry-propagate adder of the chain.
    assign acc_out = st_q.s[STAGES-1] + st_q.c[STAGES-1];

    // R7: no integrator state moves on an idle cycle
    a_r7_integ_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(acc_out));

    // R1: reset leaves the integrators at zero
    a_r1_integ_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (acc_out == '0));

endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
    parameter int IN_W    = 12,
    parameter int REG_W   = 24,
    parameter int STAGES  = 3,
    parameter int MAX_LOG = 4,
    parameter int LOG_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [LOG_W-1:0] shift_log,
    input  logic [REG_W-1:0] data_in,
    output logic             out_valid,
    output logic [IN_W-1:0]  out_data
);

    localparam int SH_W = cic_pkg::bits_for(STAGES * MAX_LOG);

    typedef struct packed {
        logic [STAGES-1:0][REG_W-1:0] dly;
        logic [IN_W-1:0]              dout;
        logic                         vld;
    } comb_t;

    comb_t             st_d, st_q;
    logic [REG_W-1:0]  stage_in [STAGES+1];
    logic [SH_W-1:0]   sh;

    always_comb begin
        stage_in[0] = data_in;
        for (int i = 0; i < STAGES; i++) begin
            stage_in[i+1] = stage_in[i] - st_q.dly[i];
        end
        sh       = SH_W'(STAGES) * SH_W'(shift_log);
        st_d     = st_q;
        st_d.vld = take;
        if (take) begin
            for (int i = 0; i < STAGES; i++) begin
                st_d.dly[i] = stage_in[i];
            end
            st_d.dout = IN_W'($signed(stage_in[STAGES]) >>> sh);
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.dout;

    // R2: the output strobe follows the period strobe by one edge
    a_r2_take_to_valid: assert property (@(posedge clk) disable iff (rst)
        take |=> out_valid);

    // R2: output data is held between strobes
    a_r2_data_hold: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(out_data));

endmodule

// File: rtl/cic_decim.sv
module cic_decim #(
    parameter int IN_W    = 12,
    parameter int STAGES  = 3,
    parameter int MAX_LOG = 4,
    parameter int SEL_W   = (MAX_LOG > 1) ? $clog2(MAX_LOG) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             out_valid,
    output logic [IN_W-1:0]  out_data
);

    localparam int REG_W = IN_W + STAGES * MAX_LOG;
    localparam int LOG_W = cic_pkg::bits_for(MAX_LOG);

    typedef struct packed {
        logic             take;
        logic [LOG_W-1:0] lg;
    } pipe_t;

    pipe_t             pipe_d, pipe_q;
    logic              strobe;
    logic [LOG_W-1:0]  cur_log;
    logic [REG_W-1:0]  acc;

    cic_rate_ctrl #(
        .MAX_LOG (MAX_LOG),
        .SEL_W   (SEL_W),
        .LOG_W   (LOG_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .rate_sel (rate_sel),
        .strobe   (strobe),
        .cur_log  (cur_log)
    );

    cic_integ_chain #(
        .IN_W   (IN_W),
        .REG_W  (REG_W),
        .STAGES (STAGES)
    ) u_integ (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .acc_out  (acc)
    );

    // The integrator result of a closing sample is ready one edge later;
    // the scale of the closing period travels with it.
    always_comb begin
        pipe_d      = pipe_q;
        pipe_d.take = strobe;
        if (strobe) pipe_d.lg = cur_log;
        if (rst) pipe_d = '0;
    end

    always_ff @(posedge clk) begin
        pipe_q <= pipe_d;
    end

    cic_comb_chain #(
        .IN_W    (IN_W),
        .REG_W   (REG_W),
        .STAGES  (STAGES),
        .MAX_LOG (MAX_LOG),
        .LOG_W   (LOG_W)
    ) u_comb (
        .clk       (clk),
        .rst       (rst),
        .take      (pipe_q.take),
        .shift_log (pipe_q.lg),
        .data_in   (acc),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // R1: quiet output right after reset
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && out_data == '0));

    // R2: never two output strobes in a row
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R2: a closing sample leads to the pipeline take on the next edge
    a_r2_strobe_to_take: assert property (@(posedge clk) disable iff (rst)
        strobe |=> pipe_q.take);

    // R4: the scale used for the output is the one in force during the period
    a_r4_old_scale: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (pipe_q.lg == $past(cur_log)));

endmodule

// File: tb/sim_cic_decim.sv
`timescale 1ns/1ps
module sim_cic_decim;

    localparam int IN_W    = 12;
    localparam int STAGES  = 3;
    localparam int MAX_LOG = 4;
    localparam int SEL_W   = 2;
    localparam int REG_W   = IN_W + STAGES * MAX_LOG;
    localparam longint MASK = (longint'(1) << REG_W) - 1;

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid;
    logic [IN_W-1:0]  in_data;
    logic [SEL_W-1:0] rate_sel;
    logic             out_valid;
    logic [IN_W-1:0]  out_data;

    int     checks = 0;
    int     errors = 0;
    int     pulses = 0;
    longint last_out = 0;
    string  cur_req = "R1";
    bit     finished = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    cic_decim #(
        .IN_W    (IN_W),
        .STAGES  (STAGES),
        .MAX_LOG (MAX_LOG),
        .SEL_W   (SEL_W)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .rate_sel  (rate_sel),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural model of the requirements ----------------
    longint      m_int [STAGES];
    longint      m_dly [STAGES];
    int          m_cnt;
    int          m_lg;
    bit          pend_v, exp_v;
    longint      pend_d, exp_d;

    function automatic longint wrapw(input longint v);
        return v & MASK;
    endfunction

    function automatic longint as_signed(input longint v);
        longint w;
        w = v & MASK;
        if (w[REG_W-1]) return w - (longint'(1) << REG_W);
        return w;
    endfunction

    function automatic int code_log(input int code);
        return (code + 1 > MAX_LOG) ? MAX_LOG : code + 1;
    endfunction

    always @(posedge clk) begin
        exp_v  = pend_v;
        exp_d  = pend_d;
        pend_v = 1'b0;
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                m_int[i] = 0;
                m_dly[i] = 0;
            end
            m_cnt  = 0;
            m_lg   = code_log(int'(rate_sel));
            exp_v  = 1'b0;
            exp_d  = 0;
        end else if (in_valid) begin
            for (int i = STAGES - 1; i > 0; i--) m_int[i] = wrapw(m_int[i] + m_int[i-1]);
            m_int[0] = wrapw(m_int[0] + longint'($signed(in_data)));
            if (m_cnt == (1 << m_lg) - 1) begin
                longint tmp, nt;
                tmp = m_int[STAGES-1];
                for (int i = 0; i < STAGES; i++) begin
                    nt       = wrapw(tmp - m_dly[i]);
                    m_dly[i] = tmp;
                    tmp      = nt;
                end
                pend_v = 1'b1;
                pend_d = as_signed(as_signed(tmp) >>> (STAGES * m_lg));
                m_cnt  = 0;
                m_lg   = code_log(int'(rate_sel));
            end else begin
                m_cnt++;
            end
        end
    end

    // ---------------- output monitor ----------------
    always @(negedge clk) begin
        if (!rst && (out_valid || exp_v)) begin
            check(out_valid == exp_v, "R2", "out_valid timing", longint'(out_valid), longint'(exp_v));
            if (out_valid && exp_v) begin
                logic [IN_W-1:0] e;
                e = IN_W'(exp_d);
                check(out_data == e, cur_req, "out_data value",
                      longint'($signed(out_data)), longint'($signed(e)));
            end
        end
        if (!rst && out_valid) begin
            pulses++;
            last_out = longint'($signed(out_data));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send(input longint x, input logic v);
        @(negedge clk);
        in_valid = v;
        in_data  = IN_W'(x);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst    = 1'b0;
        pulses = 0;
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        cur_req  = "R1";
        rate_sel = 2'd0;
        apply_reset();
        check(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
        check(out_data == '0, "R1", "out_data after reset", longint'($signed(out_data)), 0);
        idle(6);
        check(pulses == 0, "R1", "no strobe without input", pulses, 0);
    endtask

    task automatic t_dc(input int code, input longint val);
        int r, n;
        cur_req  = "R5";
        rate_sel = SEL_W'(code);
        apply_reset();
        r = 1 << code_log(code);
        n = 12 * r;
        for (int i = 0; i < n; i++) send(val, 1'b1);
        idle(4);
        check(pulses == n / r, "R3", "outputs per ratio", pulses, n / r);
        check(last_out == val, "R5", "settled DC output", last_out, val);
    endtask

    task automatic t_ratio_change();
        int k = 0;
        cur_req  = "R4";
        rate_sel = 2'd0;
        apply_reset();
        for (int i = 0; i < 7; i++) begin send(longint'(k * 37 - 600), 1'b1); k++; end
        rate_sel = 2'd3;
        send(longint'(k * 37 - 600), 1'b1); k++;
        for (int i = 0; i < 32; i++) begin send(longint'((k % 50) * 41 - 1000), 1'b1); k++; end
        idle(3);
        check(pulses == 6, "R4", "strobes after switch to 16", pulses, 6);
        for (int i = 0; i < 5; i++) begin send(longint'((k % 50) * 41 - 1000), 1'b1); k++; end
        rate_sel = 2'd1;
        for (int i = 0; i < 11; i++) begin send(longint'((k % 50) * 41 - 1000), 1'b1); k++; end
        idle(3);
        check(pulses == 7, "R4", "mid-period change keeps old ratio", pulses, 7);
        for (int i = 0; i < 8; i++) begin send(longint'((k % 50) * 41 - 1000), 1'b1); k++; end
        idle(3);
        check(pulses == 9, "R4", "strobes after switch to 4", pulses, 9);
    endtask

    task automatic t_gaps();
        int acc = 0;
        longint held;
        cur_req  = "R7";
        rate_sel = 2'd2;
        apply_reset();
        for (int i = 0; i < 160; i++) begin
            step_lfsr();
            send(longint'($signed(lfsr[IN_W-1:0])), lfsr[15] | lfsr[3]);
            if (lfsr[15] | lfsr[3]) acc++;
            if (i == 80) begin
                idle(20);
                held = last_out;
                idle(20);
                check(last_out == held, "R7", "output held while idle", last_out, held);
            end
        end
        idle(30);
        check(pulses == acc / 8, "R7", "strobes count only accepted samples", pulses, acc / 8);
    endtask

    task automatic t_noise(input int code);
        cur_req  = "R6";
        rate_sel = SEL_W'(code);
        apply_reset();
        for (int i = 0; i < 200; i++) begin
            step_lfsr();
            send(longint'($signed(lfsr[IN_W-1:0])), 1'b1);
        end
        idle(4);
        check(pulses == 200 / (1 << code_log(code)), "R6", "noise output count",
              pulses, 200 / (1 << code_log(code)));
    endtask

    task automatic t_wrap();
        longint lo, hi;
        lo = -(longint'(1) << (IN_W - 1));
        hi = (longint'(1) << (IN_W - 1)) - 1;
        cur_req  = "R8";
        rate_sel = 2'd3;
        apply_reset();
        for (int i = 0; i < 20 * 16; i++) send(lo, 1'b1);
        idle(4);
        check(last_out == lo, "R8", "full-scale negative DC", last_out, lo);
        for (int i = 0; i < 20 * 16; i++) send(hi, 1'b1);
        idle(4);
        check(last_out == hi, "R8", "full-scale positive DC", last_out, hi);
    endtask

    initial begin
        rst      = 1'b1;
        in_valid = 1'b0;
        in_data  = '0;
        rate_sel = '0;
        pend_v   = 1'b0;
        exp_v    = 1'b0;
        pend_d   = 0;
        exp_d    = 0;
        t_reset();
        t_dc(0, 1000);
        t_dc(1, -700);
        t_dc(2, 345);
        t_dc(3, -1234);
        t_ratio_change();
        t_gaps();
        t_noise(0);
        t_noise(1);
        t_wrap();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", 100000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule